// File: doc/BRIEF.md
# Non-volatile Configuration Image Cache and Validator

This block sits above an engine that reads and writes single 16-bit words of a small serial configuration memory. On demand it pulls the whole 64-word image into a local cache, adds the words together as it goes, and judges the image trustworthy only if the wrapped sum hits a fixed target and a signature field in word 0 carries the expected pattern. Once the cache is trusted, word lookups are answered locally without touching the memory, and a 32-bit assembly number is presented from two of the cached words.

Two write paths go through the engine. The first is a plain word write. The second is a checksum repair that re-reads words 0 to 62 and stores the correcting value into word 63. Both paths drop the cached signature, so the next lookup rebuilds the cache from the memory.

Top module: `nvm_image_loader`

## Requirements
- R1: After reset, busy, eng_req, lk_ack, load_done, csum_ok, sig_ok and cache_valid are all 0, and asm_number reads 0.
- R2: A load issues exactly 64 engine reads (eng_we=0) at addresses 0, 1, 2 … 63 in ascending order and stores each returned word in the cache.
- R3: If the 16-bit sum of the 64 loaded words, taken modulo 2^16, differs from 16'hBABA, the load ends with csum_ok=0, sig_ok=0 and cache_valid=0, and the pending lookup answers 0.
- R4: If the sum is correct but word 0 ANDed with 16'hC000 is not 16'h4000, the load ends with csum_ok=1, sig_ok=0, cache_valid=0 and the lookup answers 0.
- R5: A lookup with index below 64 while cache_valid=1 issues no engine access and answers the cached word.
- R6: A lookup with index below 64 while cache_valid=0 first performs a complete load, then answers the cached word if the load succeeded.
- R7: A lookup with index 64 or above answers 0 and issues no engine access, whatever the cache state.
- R8: A checksum update reads words 0 to 62 in order, then writes 16'hBABA minus their 16-bit sum to address 63, after which cache_valid=0.
- R9: A word write passes its address and data to the engine as one write access; after its completion cache_valid=0.
- R10: asm_number equals {word 9, word 8} of the cache while cache_valid=1 and reads 0 otherwise.
- R11: load_done pulses for exactly one cycle per load; csum_ok and sig_ok keep the results of the latest load until the next load ends.
- R12: Requests raised together while idle are served by priority write, then update, then lookup; the lower-priority requests of that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle pulse: write a word |
| wr_addr | input | 6 | Address for the word write |
| wr_data | input | 16 | Data for the word write |
| upd_req | input | 1 | One-cycle pulse: recompute and store the checksum word |
| lk_req | input | 1 | One-cycle pulse: look up a word |
| lk_index | input | 8 | Lookup index; 64 and above is out of range |
| lk_ack | output | 1 | One-cycle pulse: lookup answer valid |
| lk_data | output | 16 | Lookup answer |
| busy | output | 1 | An operation is in progress; requests are not taken |
| eng_req | output | 1 | Access request to the word engine, held until acknowledged |
| eng_we | output | 1 | 1 for a write access, 0 for a read |
| eng_addr | output | 6 | Word address of the access |
| eng_wdata | output | 16 | Write data of the access |
| eng_ack | input | 1 | One-cycle completion pulse from the engine |
| eng_rdata | input | 16 | Read data, valid with eng_ack |
| asm_number | output | 32 | Assembly number, {word 9, word 8}, 0 when invalid |
| load_done | output | 1 | One-cycle pulse at the end of each load |
| csum_ok | output | 1 | Sum check result of the latest load |
| sig_ok | output | 1 | Signature check result of the latest load |
| cache_valid | output | 1 | Cache holds a validated image |

## Verification
The assertions take for granted that the engine raises eng_ack only while eng_req is high, for one cycle per access, and waits for eng_req to drop before accepting another request; they also assume that requests arrive only while busy is low. The bench's engine model answers each access after a fixed delay and then waits for the request to fall, and every scenario task waits for busy to fall or for the lookup answer before raising the next request. The one scenario that raises several requests together does so from the idle state, which is the case the priority rule describes.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [15:0] SUM_TARGET = 16'hBABA;
  localparam logic [15:0] SIG_MASK   = 16'hC000;
  localparam logic [15:0] SIG_GOOD   = 16'h4000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_EVAL,
    ST_LK_RD,
    ST_LK_RSP,
    ST_UPD,
    ST_UPD_WR,
    ST_WR
  } ctrl_state_t;
endpackage

// File: rtl/nvm_word_ram.sv
module nvm_word_ram #(
  parameter int DW = 16,
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_sum_acc.sv
module nvm_sum_acc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] add_val,
  output logic [DW-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (add_en) sum <= sum + add_val;
  end
endmodule

// File: rtl/nvm_field_regs.sv
module nvm_field_regs
  import nvm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int SIG_ADDR = 0,
  parameter int LO_ADDR = 8,
  parameter int HI_ADDR = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic          commit,
  input  logic          commit_good,
  input  logic          sig_clear,
  output logic          stage_match,
  output logic          valid,
  output logic [DW-1:0] lo_word,
  output logic [DW-1:0] hi_word
);
  logic [DW-1:0] sig_stage;
  logic [DW-1:0] sig_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_stage <= '0;
      sig_word  <= '0;
      lo_word   <= '0;
      hi_word   <= '0;
    end else begin
      if (cap_en && cap_addr == AW'(SIG_ADDR)) sig_stage <= cap_data;
      if (cap_en && cap_addr == AW'(LO_ADDR))  lo_word   <= cap_data;
      if (cap_en && cap_addr == AW'(HI_ADDR))  hi_word   <= cap_data;
      if (commit)
        sig_word <= commit_good ? sig_stage : (sig_stage & ~SIG_MASK);
      else if (sig_clear)
        sig_word <= sig_word & ~SIG_MASK;
    end
  end

  assign stage_match = (sig_stage & SIG_MASK) == SIG_GOOD;
  assign valid       = (sig_word & SIG_MASK) == SIG_GOOD;
endmodule

// File: rtl/nvm_loader_ctrl.sv
module nvm_loader_ctrl
  import nvm_pkg::*;
#(
  parameter int DW = 16,
  parameter int WORDS = 64,
  parameter int IW = 8,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          upd_req,
  input  logic          lk_req,
  input  logic [IW-1:0] lk_index,
  output logic          lk_ack,
  output logic [DW-1:0] lk_data,
  output logic          busy,
  output logic          eng_req,
  output logic          eng_we,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_wdata,
  input  logic          eng_ack,
  input  logic [DW-1:0] eng_rdata,
  input  logic          cache_valid,
  input  logic          stage_match,
  input  logic [DW-1:0] sum,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [AW-1:0] ram_raddr,
  output logic          sum_clr,
  output logic          sum_add,
  output logic          commit,
  output logic          commit_good,
  output logic          sig_clear,
  output logic          load_done,
  output logic          csum_ok,
  output logic          sig_ok
);
  localparam logic [AW-1:0] LOAD_LAST = AW'(WORDS - 1);
  localparam logic [AW-1:0] UPD_LAST  = AW'(WORDS - 2);
  localparam logic [IW-1:0] IDX_LIMIT = IW'(WORDS);

  ctrl_state_t   state;
  logic [AW-1:0] cnt;
  logic [IW-1:0] idx_q;
  logic          sum_good;
  logic          issue;

  assign sum_good    = (sum == SUM_TARGET);
  assign busy        = (state != ST_IDLE);
  assign ram_we      = (state == ST_LOAD) && eng_ack;
  assign ram_waddr   = cnt;
  assign ram_raddr   = idx_q[AW-1:0];
  assign sum_clr     = (state == ST_IDLE);
  assign sum_add     = ((state == ST_LOAD) || (state == ST_UPD)) && eng_ack;
  assign commit      = (state == ST_EVAL);
  assign commit_good = sum_good;
  assign sig_clear   = eng_ack && eng_we;
  assign issue       = !eng_req && !eng_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx_q     <= '0;
      eng_req   <= 1'b0;
      eng_we    <= 1'b0;
      eng_addr  <= '0;
      eng_wdata <= '0;
      lk_ack    <= 1'b0;
      lk_data   <= '0;
      load_done <= 1'b0;
      csum_ok   <= 1'b0;
      sig_ok    <= 1'b0;
    end else begin
      lk_ack    <= 1'b0;
      load_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_req) begin
            eng_req   <= 1'b1;
            eng_we    <= 1'b1;
            eng_addr  <= wr_addr;
            eng_wdata <= wr_data;
            state     <= ST_WR;
          end else if (upd_req) begin
            cnt   <= '0;
            state <= ST_UPD;
          end else if (lk_req) begin
            idx_q <= lk_index;
            if (lk_index >= IDX_LIMIT) begin
              lk_ack  <= 1'b1;
              lk_data <= '0;
            end else if (cache_valid) begin
              state <= ST_LK_RD;
            end else begin
              cnt   <= '0;
              state <= ST_LOAD;
            end
          end
        end
        ST_LOAD, ST_UPD: begin
          if (issue) begin
            eng_req  <= 1'b1;
            eng_we   <= 1'b0;
            eng_addr <= cnt;
          end
          if (eng_ack) begin
            eng_req <= 1'b0;
            if (state == ST_LOAD && cnt == LOAD_LAST) state <= ST_EVAL;
            else if (state == ST_UPD && cnt == UPD_LAST) state <= ST_UPD_WR;
            else cnt <= cnt + 1'b1;
          end
        end
        ST_EVAL: begin
          csum_ok   <= sum_good;
          sig_ok    <= sum_good && stage_match;
          load_done <= 1'b1;
          if (sum_good && stage_match) begin
            state <= ST_LK_RD;
          end else begin
            lk_ack  <= 1'b1;
            lk_data <= '0;
            state   <= ST_IDLE;
          end
        end
        ST_LK_RD: state <= ST_LK_RSP;
        ST_LK_RSP: begin
          lk_ack  <= 1'b1;
          lk_data <= ram_rdata;
          state   <= ST_IDLE;
        end
        ST_UPD_WR: begin
          if (issue) begin
            eng_req   <= 1'b1;
            eng_we    <= 1'b1;
            eng_addr  <= LOAD_LAST;
            eng_wdata <= SUM_TARGET - sum;
          end
          if (eng_ack) begin
            eng_req <= 1'b0;
            eng_we  <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (eng_ack) begin
            eng_req <= 1'b0;
            eng_we  <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_image_loader.sv
module nvm_image_loader #(
  parameter int DW = 16,
  parameter int WORDS = 64,
  parameter int IW = 8,
  parameter int SIG_ADDR = 0,
  parameter int LO_ADDR = 8,
  parameter int HI_ADDR = 9,
  localparam int AW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            upd_req,
  input  logic            lk_req,
  input  logic [IW-1:0]   lk_index,
  output logic            lk_ack,
  output logic [DW-1:0]   lk_data,
  output logic            busy,
  output logic            eng_req,
  output logic            eng_we,
  output logic [AW-1:0]   eng_addr,
  output logic [DW-1:0]   eng_wdata,
  input  logic            eng_ack,
  input  logic [DW-1:0]   eng_rdata,
  output logic [2*DW-1:0] asm_number,
  output logic            load_done,
  output logic            csum_ok,
  output logic            sig_ok,
  output logic            cache_valid
);
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [AW-1:0] ram_raddr;
  logic [DW-1:0] ram_rdata;
  logic          sum_clr;
  logic          sum_add;
  logic [DW-1:0] sum;
  logic          commit;
  logic          commit_good;
  logic          sig_clear;
  logic          stage_match;
  logic [DW-1:0] lo_word;
  logic [DW-1:0] hi_word;

  nvm_word_ram #(.DW(DW), .WORDS(WORDS)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(eng_rdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  nvm_sum_acc #(.DW(DW)) u_sum (
    .clk(clk), .rst(rst), .clr(sum_clr), .add_en(sum_add),
    .add_val(eng_rdata), .sum(sum)
  );

  nvm_field_regs #(
    .DW(DW), .AW(AW), .SIG_ADDR(SIG_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_fields (
    .clk(clk), .rst(rst), .cap_en(ram_we), .cap_addr(ram_waddr),
    .cap_data(eng_rdata), .commit(commit), .commit_good(commit_good),
    .sig_clear(sig_clear), .stage_match(stage_match), .valid(cache_valid),
    .lo_word(lo_word), .hi_word(hi_word)
  );

  nvm_loader_ctrl #(.DW(DW), .WORDS(WORDS), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_req(upd_req), .lk_req(lk_req), .lk_index(lk_index),
    .lk_ack(lk_ack), .lk_data(lk_data), .busy(busy),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .cache_valid(cache_valid), .stage_match(stage_match), .sum(sum),
    .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_raddr(ram_raddr), .sum_clr(sum_clr), .sum_add(sum_add),
    .commit(commit), .commit_good(commit_good), .sig_clear(sig_clear),
    .load_done(load_done), .csum_ok(csum_ok), .sig_ok(sig_ok)
  );

  assign asm_number = cache_valid ? {hi_word, lo_word} : '0;
endmodule

// File: rtl/nvm_loader_checks.sv
module nvm_loader_checks #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          eng_req,
  input logic          eng_we,
  input logic [AW-1:0] eng_addr,
  input logic          eng_ack,
  input logic          lk_ack,
  input logic [DW-1:0] lk_data,
  input logic          load_done,
  input logic          csum_ok,
  input logic          cache_valid
);
  // R2: each new read request continues the ascending sequence
  assert_read_order_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(eng_req) && !eng_we && eng_addr != '0) |-> eng_addr == $past(eng_addr) + 1'b1);

  // R3: a failed sum never leaves a trusted cache
  assert_bad_sum_invalid_R3: assert property (@(posedge clk) disable iff (rst)
    (load_done && !csum_ok) |-> !cache_valid);

  // R6: the cache only becomes trusted at the end of a successful load
  assert_valid_after_load_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cache_valid) |-> load_done);

  // R9: a completed write drops the trusted state
  assert_write_invalidates_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_ack && eng_we) |=> !cache_valid);

  // R3: answers given without a trusted cache are zero
  assert_untrusted_answer_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_ack && !cache_valid) |-> lk_data == '0);

  // R11: completion pulses last one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);

  // R5: lookup answer is a single-cycle pulse
  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    lk_ack |=> !lk_ack);

  // R1: no engine access outside an operation
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !eng_req);
endmodule

bind nvm_image_loader nvm_loader_checks #(.DW(DW), .AW(AW)) u_checks (
  .clk(clk), .rst(rst), .busy(busy), .eng_req(eng_req), .eng_we(eng_we),
  .eng_addr(eng_addr), .eng_ack(eng_ack), .lk_ack(lk_ack), .lk_data(lk_data),
  .load_done(load_done), .csum_ok(csum_ok), .cache_valid(cache_valid)
);

// File: tb/nvm_image_loader_test.sv
module nvm_image_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        upd_req = 1'b0;
  logic        lk_req = 1'b0;
  logic [7:0]  lk_index = '0;
  logic        lk_ack;
  logic [15:0] lk_data;
  logic        busy;
  logic        eng_req;
  logic        eng_we;
  logic [5:0]  eng_addr;
  logic [15:0] eng_wdata;
  logic        eng_ack = 1'b0;
  logic [15:0] eng_rdata = '0;
  logic [31:0] asm_number;
  logic        load_done;
  logic        csum_ok;
  logic        sig_ok;
  logic        cache_valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] img [64];
  int          op_cnt = 0;
  logic [5:0]  op_addr [256];
  logic        op_we [256];
  logic [15:0] op_wdata [256];
  int          done_cnt = 0;
  bit          got_ack = 0;
  logic [15:0] got_data = '0;
  int          ack_cnt = 0;

  always #5 clk = ~clk;

  nvm_image_loader uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_req(upd_req), .lk_req(lk_req), .lk_index(lk_index), .lk_ack(lk_ack),
    .lk_data(lk_data), .busy(busy), .eng_req(eng_req), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata), .asm_number(asm_number), .load_done(load_done),
    .csum_ok(csum_ok), .sig_ok(sig_ok), .cache_valid(cache_valid)
  );

  // engine model: fixed latency, then waits for the request to drop
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req && !rst) begin
        if (op_cnt < 256) begin
          op_addr[op_cnt]  = eng_addr;
          op_we[op_cnt]    = eng_we;
          op_wdata[op_cnt] = eng_wdata;
        end
        op_cnt++;
        repeat (3) @(negedge clk);
        if (eng_we) img[eng_addr] = eng_wdata;
        eng_rdata = img[eng_addr];
        eng_ack = 1'b1;
        @(negedge clk);
        eng_ack = 1'b0;
        while (eng_req) @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (load_done) done_cnt++;
    if (lk_ack) begin
      got_ack  = 1;
      got_data = lk_data;
      ack_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + img[i];
    return s;
  endfunction

  task automatic clear_log();
    op_cnt = 0;
    done_cnt = 0;
  endtask

  task automatic do_lookup(input logic [7:0] idx, output logic [15:0] data);
    int t = 0;
    got_ack = 0;
    @(negedge clk);
    lk_req = 1'b1;
    lk_index = idx;
    @(negedge clk);
    lk_req = 1'b0;
    while (!got_ack && t < 2000) begin
      @(negedge clk);
      t++;
    end
    data = got_data;
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_req = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_update();
    @(negedge clk);
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !eng_req && !lk_ack && !load_done, "R1 control idle",
          {28'd0, busy, eng_req, lk_ack, load_done}, 32'd0);
    check(!csum_ok && !sig_ok && !cache_valid, "R1 flags clear",
          {29'd0, csum_ok, sig_ok, cache_valid}, 32'd0);
    check(asm_number == 32'd0, "R1 asm zero", asm_number, 32'd0);
  endtask

  task automatic t_first_load();
    logic [15:0] d;
    int misorder = 0;
    clear_log();
    do_lookup(8'd5, d);
    check(op_cnt == 64, "R6 full load before answer", op_cnt, 64);
    for (int i = 0; i < 64; i++)
      if (op_addr[i] != 6'(i) || op_we[i]) misorder++;
    check(misorder == 0, "R2 ascending read order", misorder, 0);
    check(d == img[5], "R6 answer after load", d, img[5]);
    check(done_cnt == 1, "R11 one done pulse", done_cnt, 1);
    check(csum_ok && sig_ok && cache_valid, "R11 good flags",
          {29'd0, csum_ok, sig_ok, cache_valid}, 32'd7);
    check(asm_number == {img[9], img[8]}, "R10 asm number", asm_number, {img[9], img[8]});
  endtask

  task automatic t_cached();
    logic [15:0] d;
    clear_log();
    do_lookup(8'd63, d);
    check(d == img[63], "R5 cached word 63", d, img[63]);
    do_lookup(8'd0, d);
    check(d == img[0], "R5 cached word 0", d, img[0]);
    check(op_cnt == 0, "R5 no engine access", op_cnt, 0);
    check(csum_ok && sig_ok, "R11 flags held", {30'd0, csum_ok, sig_ok}, 32'd3);
  endtask

  task automatic t_range();
    logic [15:0] d;
    clear_log();
    do_lookup(8'd64, d);
    check(d == 16'd0, "R7 index 64", d, 0);
    do_lookup(8'd255, d);
    check(d == 16'd0, "R7 index 255", d, 0);
    check(op_cnt == 0 && cache_valid, "R7 no access, cache kept",
          {op_cnt[30:0], cache_valid}, 32'd1);
  endtask

  task automatic t_write();
    clear_log();
    do_write(6'd10, 16'h5A5A);
    check(op_cnt == 1 && op_we[0] && op_addr[0] == 6'd10 && op_wdata[0] == 16'h5A5A,
          "R9 engine write", {op_addr[0], op_wdata[0]}, {6'd10, 16'h5A5A});
    check(!cache_valid, "R9 invalid after write", cache_valid, 0);
    check(asm_number == 32'd0, "R10 asm zero when invalid", asm_number, 0);
  endtask

  task automatic t_bad_sum();
    logic [15:0] d;
    clear_log();
    do_lookup(8'd10, d);
    check(op_cnt == 64, "R3 reload on invalid", op_cnt, 64);
    check(d == 16'd0, "R3 answer zero", d, 0);
    check(!csum_ok && !sig_ok && !cache_valid, "R3 flags",
          {29'd0, csum_ok, sig_ok, cache_valid}, 0);
    clear_log();
    do_lookup(8'd10, d);
    check(op_cnt == 64 && done_cnt == 1, "R3 reload repeats", op_cnt, 64);
  endtask

  task automatic t_update();
    logic [15:0] d;
    logic [15:0] exp;
    int misorder = 0;
    exp = 16'hBABA - sum_to(62);
    clear_log();
    do_update();
    check(op_cnt == 64, "R8 access count", op_cnt, 64);
    for (int i = 0; i < 63; i++)
      if (op_addr[i] != 6'(i) || op_we[i]) misorder++;
    check(misorder == 0, "R8 read order", misorder, 0);
    check(op_we[63] && op_addr[63] == 6'd63 && op_wdata[63] == exp, "R8 checksum write",
          {op_addr[63], op_wdata[63]}, {6'd63, exp});
    check(!cache_valid, "R8 invalid after update", cache_valid, 0);
    do_lookup(8'd10, d);
    check(d == 16'h5A5A && csum_ok && sig_ok, "R8 image good again", d, 16'h5A5A);
  endtask

  task automatic t_bad_sig();
    logic [15:0] d;
    do_write(6'd0, 16'h8123);
    do_update();
    do_lookup(8'd3, d);
    check(d == 16'd0, "R4 answer zero", d, 0);
    check(csum_ok && !sig_ok && !cache_valid, "R4 flags",
          {29'd0, csum_ok, sig_ok, cache_valid}, 32'd4);
    check(asm_number == 32'd0, "R4 asm zero", asm_number, 0);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    int acks;
    do_write(6'd0, 16'h4123);
    do_update();
    do_lookup(8'd1, d);
    check(cache_valid && d == img[1], "R12 setup valid", d, img[1]);
    clear_log();
    acks = ack_cnt;
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 6'd20; wr_data = 16'h0F0F;
    upd_req = 1'b1; lk_req = 1'b1; lk_index = 8'd2;
    @(negedge clk);
    wr_req = 1'b0; upd_req = 1'b0; lk_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check(op_cnt == 1 && op_we[0] && op_addr[0] == 6'd20, "R12 write wins",
          op_cnt, 1);
    check(ack_cnt == acks && !busy, "R12 others dropped", ack_cnt - acks, 0);
  endtask

  initial begin
    img[0] = 16'h4123;
    for (int i = 1; i < 63; i++) img[i] = 16'(i * 16'h0397 + 16'h1F00);
    img[8] = 16'h1234;
    img[9] = 16'hABCD;
    img[63] = 16'hBABA - sum_to(62);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_load();
    t_cached();
    t_range();
    t_write();
    t_bad_sum();
    t_update();
    t_bad_sig();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule